// File: doc/BRIEF.md
# Ternary Road Finder

The block keeps a small bank of track patterns, each describing the expected hit word on eight detector layers. Every layer entry of a pattern is a 12-bit word with a 2-bit don't-care code. The code says how many of the word's lowest bits are left out of the comparison. A pattern can therefore sit at fine resolution on one layer and at coarse resolution on another, and coarse and fine patterns can share the bank. During an event, hit words arrive on eight parallel buses, one per layer, at up to one word per bus per cycle. Every stored pattern compares every accepted hit on its layers at once. A layer that sees a matching hit is flagged, and the flag stays set until the event ends.

An end-of-event marker closes the event. One cycle later the block takes a snapshot of every loaded pattern whose count of flagged layers reaches the threshold input. These patterns are the roads. It then clears all flags. The road addresses are streamed out in ascending order, one per valid/ready handshake. While the output is stalled, `road_valid` stays high and `road_addr` does not change. Patterns are written through a load port that is open only while no event is under way.

All three inputs (load, hits, end-of-event) and the road output use valid/ready. A producer may hold its valid high for as long as it likes. A transfer happens only on a rising clock edge where valid and ready are both high. `hit_ready` is shared by all eight lanes. `thresh` is a plain control input and is read in the snapshot cycle.

Top module: `pattern_road_finder`

## Requirements
- R1: `load_ready` is high after reset and whenever no event is open. It goes low in the cycle after the first hit is accepted and stays low until the readout ends. A load offered while `load_ready` is low changes nothing.
- R2: A layer matches when the hit word equals the stored word on every bit above the masked low bits. Don't-care code 0 masks no bits, code 1 masks bit 0, and code 2 masks bits 1:0. Code 3 behaves exactly like code 2, so bit 2 is still compared.
- R3: A layer flag sets on any matching hit on that layer's bus and then stays set for the rest of the event. Later non-matching hits on that layer do not clear it, and the order of the hits does not matter.
- R4: A loaded pattern becomes a road when its number of flagged layers is at least `thresh` (0 to 8). The value of `thresh` is taken in the cycle after the end-of-event marker is accepted.
- R5: A pattern slot that has never been loaded since reset never produces a road, even when `thresh` is 0.
- R6: `hit_ready` and `eoe_ready` are high except during the snapshot cycle and the readout. The eight lanes are independent, so any subset of lanes may carry a hit in the same cycle.
- R7: Hits accepted in the same cycle as the end-of-event marker count toward that event.
- R8: Roads are presented in strictly ascending address order, one per handshake. While `road_ready` is low, `road_valid` stays high and `road_addr` holds its value.
- R9: After the last road is taken, or right after the snapshot if there are no roads, the block returns to idle with all flags cleared and `load_ready` high. The next event therefore starts clean.
- R10: A load and a hit accepted in the same idle cycle both take effect. The hit is compared against the pattern contents from before the write.
- R11: After an end-of-event marker is accepted, `road_valid` and `hit_ready` are low in the following cycle (the snapshot cycle). `road_valid` can be high from the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 4 | Minimum number of flagged layers for a road |
| load_valid | input | 1 | Pattern write offered |
| load_ready | output | 1 | Pattern write can be accepted (no event open) |
| load_addr | input | 4 | Pattern slot to write |
| load_words | input | 96 | Eight 12-bit layer words, layer n at bits 12n+11:12n |
| load_dc | input | 16 | Eight 2-bit don't-care codes, layer n at bits 2n+1:2n |
| hit_valid | input | 8 | Per-layer hit present |
| hit_ready | output | 1 | Hits accepted on all lanes this cycle |
| hit_words | input | 96 | Eight 12-bit hit words, lane n at bits 12n+11:12n |
| eoe_valid | input | 1 | End-of-event marker offered |
| eoe_ready | output | 1 | End-of-event marker can be accepted |
| road_valid | output | 1 | A road address is presented |
| road_ready | input | 1 | Consumer takes the road address |
| road_addr | output | 4 | Address of the road pattern |

## Verification
Two pairs of functions can fall in the same cycle. The first is a pattern write and the first hit of an event: the bench offers a load and a full set of hits equal to the new pattern in the same idle cycle. It then checks that this slot does not become a road, and that a second write offered later in the same event is refused, which is shown by the road produced in the following event. The second is the last hits of an event and the end-of-event marker: the remaining layers of a pattern are presented together with the marker, and a road is required at full threshold. A bench model of flags and patterns, built from the requirements, predicts the ordered road list for every event.

// File: rtl/prf_pkg.sv
package prf_pkg;

  // Event sequencing: idle (no hits yet), open (hits seen), snapshot, readout
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_OPEN  = 2'd1,
    EV_SNAP  = 2'd2,
    EV_DRAIN = 2'd3
  } ev_state_t;

endpackage

// File: rtl/prf_pattern_row.sv
module prf_pattern_row #(
  parameter int LAYERS = 8,
  parameter int WORD_W = 12,
  parameter int DC_W   = 2,
  parameter int MAX_DC = 2,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [LAYERS*WORD_W-1:0] wr_words,
  input  logic [LAYERS*DC_W-1:0]   wr_dc,
  input  logic [LAYERS-1:0]        hit_take,
  input  logic [LAYERS*WORD_W-1:0] hit_words,
  input  logic                     clear,
  input  logic [CNT_W-1:0]         thresh,
  output logic                     fire
);

  logic [LAYERS*WORD_W-1:0] words_q;
  logic [LAYERS*DC_W-1:0]   dc_q;
  logic                     loaded_q;
  logic [LAYERS-1:0]        flags_q;
  logic [LAYERS-1:0]        lane_hit;
  logic [CNT_W-1:0]         matched_cnt;

  // Per-layer ternary compare: the don't-care code removes low bits
  for (genvar l = 0; l < LAYERS; l++) begin : g_lane
    logic [DC_W-1:0]   dc_code;
    logic [DC_W-1:0]   dc_eff;
    logic [WORD_W-1:0] keep;
    logic [WORD_W-1:0] diff;

    assign dc_code = dc_q[l*DC_W +: DC_W];
    assign dc_eff  = (dc_code > DC_W'(MAX_DC)) ? DC_W'(MAX_DC) : dc_code;
    assign keep    = {WORD_W{1'b1}} << dc_eff;
    assign diff    = hit_words[l*WORD_W +: WORD_W] ^ words_q[l*WORD_W +: WORD_W];
    assign lane_hit[l] = hit_take[l] && ((diff & keep) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_q  <= '0;
      dc_q     <= '0;
      loaded_q <= 1'b0;
    end else if (wr_en) begin
      words_q  <= wr_words;
      dc_q     <= wr_dc;
      loaded_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (clear) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_q | lane_hit;
    end
  end

  always_comb begin
    matched_cnt = '0;
    for (int l = 0; l < LAYERS; l++) begin
      matched_cnt = matched_cnt + CNT_W'(flags_q[l]);
    end
  end

  assign fire = loaded_q && (matched_cnt >= thresh);

endmodule

// File: rtl/prf_pick.sv
module prf_pick #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [AW-1:0] idx,
  output logic [N-1:0]  grant
);

  // Lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any      = 1'b1;
        idx      = AW'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit_any,
  input  logic      eoe_valid,
  input  logic      fired_any,
  input  logic      pend_left,
  output ev_state_t state,
  output logic      hit_ready,
  output logic      eoe_ready,
  output logic      load_ready,
  output logic      snap
);

  ev_state_t state_q, state_d;
  logic      eoe_take;

  assign hit_ready  = (state_q == EV_IDLE) || (state_q == EV_OPEN);
  assign eoe_ready  = hit_ready;
  assign load_ready = (state_q == EV_IDLE);
  assign snap       = (state_q == EV_SNAP);
  assign eoe_take   = eoe_valid && eoe_ready;
  assign state      = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      EV_IDLE: begin
        if (eoe_take)     state_d = EV_SNAP;
        else if (hit_any) state_d = EV_OPEN;
      end
      EV_OPEN: begin
        if (eoe_take) state_d = EV_SNAP;
      end
      EV_SNAP: begin
        state_d = fired_any ? EV_DRAIN : EV_IDLE;
      end
      EV_DRAIN: begin
        if (!pend_left) state_d = EV_IDLE;
      end
      default: state_d = EV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= EV_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pattern_road_finder.sv
module pattern_road_finder
  import prf_pkg::*;
#(
  parameter int NUM_LAYERS   = 8,
  parameter int WORD_W       = 12,
  parameter int DC_W         = 2,
  parameter int MAX_DC       = 2,
  parameter int NUM_PATTERNS = 16,
  localparam int AW    = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1,
  localparam int CNT_W = $clog2(NUM_LAYERS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CNT_W-1:0]             thresh,
  input  logic                         load_valid,
  output logic                         load_ready,
  input  logic [AW-1:0]                load_addr,
  input  logic [NUM_LAYERS*WORD_W-1:0] load_words,
  input  logic [NUM_LAYERS*DC_W-1:0]   load_dc,
  input  logic [NUM_LAYERS-1:0]        hit_valid,
  output logic                         hit_ready,
  input  logic [NUM_LAYERS*WORD_W-1:0] hit_words,
  input  logic                         eoe_valid,
  output logic                         eoe_ready,
  output logic                         road_valid,
  input  logic                         road_ready,
  output logic [AW-1:0]                road_addr
);

  ev_state_t               state;
  logic                    snap;
  logic [NUM_LAYERS-1:0]   hit_take;
  logic [NUM_PATTERNS-1:0] fired;
  logic [NUM_PATTERNS-1:0] pending_q;
  logic [NUM_PATTERNS-1:0] pending_d;
  logic [NUM_PATTERNS-1:0] grant;
  logic                    pend_any;
  logic                    load_take;

  assign hit_take  = hit_valid & {NUM_LAYERS{hit_ready}};
  assign load_take = load_valid && load_ready;

  prf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_any    (|hit_take),
    .eoe_valid  (eoe_valid),
    .fired_any  (|fired),
    .pend_left  (|pending_d),
    .state      (state),
    .hit_ready  (hit_ready),
    .eoe_ready  (eoe_ready),
    .load_ready (load_ready),
    .snap       (snap)
  );

  for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_row
    prf_pattern_row #(
      .LAYERS (NUM_LAYERS),
      .WORD_W (WORD_W),
      .DC_W   (DC_W),
      .MAX_DC (MAX_DC),
      .CNT_W  (CNT_W)
    ) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (load_take && (load_addr == AW'(p))),
      .wr_words  (load_words),
      .wr_dc     (load_dc),
      .hit_take  (hit_take),
      .hit_words (hit_words),
      .clear     (snap),
      .thresh    (thresh),
      .fire      (fired[p])
    );
  end

  prf_pick #(
    .N  (NUM_PATTERNS),
    .AW (AW)
  ) u_pick (
    .req   (pending_q),
    .any   (pend_any),
    .idx   (road_addr),
    .grant (grant)
  );

  assign road_valid = (state == EV_DRAIN) && pend_any;

  always_comb begin
    pending_d = pending_q;
    if (snap) begin
      pending_d = fired;
    end else if (road_valid && road_ready) begin
      pending_d = pending_q & ~grant;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= pending_d;
  end

endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int NUM_LAYERS = 8,
  parameter int AW         = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  load_ready,
  input logic [NUM_LAYERS-1:0] hit_valid,
  input logic                  hit_ready,
  input logic                  eoe_valid,
  input logic                  eoe_ready,
  input logic                  road_valid,
  input logic                  road_ready,
  input logic [AW-1:0]         road_addr
);

  logic          seen_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (load_ready) begin
      seen_q <= 1'b0;
    end else if (road_valid && road_ready) begin
      seen_q <= 1'b1;
      last_q <= road_addr;
    end
  end

  assert_load_shut_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_valid) && hit_ready) |=> !load_ready);

  assert_drain_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid |-> (!hit_ready && !eoe_ready));

  assert_snap_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoe_valid && eoe_ready) |=> (!road_valid && !hit_ready));

  assert_road_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && !road_ready) |=> (road_valid && $stable(road_addr)));

  assert_road_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && road_ready && seen_q) |-> (road_addr > last_q));

  assert_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_ready) |-> (hit_ready && eoe_ready && !road_valid));

endmodule

bind pattern_road_finder prf_checker #(
  .NUM_LAYERS (NUM_LAYERS),
  .AW         (AW)
) u_prf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_ready (load_ready),
  .hit_valid  (hit_valid),
  .hit_ready  (hit_ready),
  .eoe_valid  (eoe_valid),
  .eoe_ready  (eoe_ready),
  .road_valid (road_valid),
  .road_ready (road_ready),
  .road_addr  (road_addr)
);

// File: tb/test_pattern_road_finder.sv
module test_pattern_road_finder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  thresh = 4'd8;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [3:0]  load_addr = '0;
  logic [95:0] load_words = '0;
  logic [15:0] load_dc = '0;
  logic [7:0]  hit_valid = '0;
  logic        hit_ready;
  logic [95:0] hit_words = '0;
  logic        eoe_valid = 1'b0;
  logic        eoe_ready;
  logic        road_valid;
  logic        road_ready = 1'b0;
  logic [3:0]  road_addr;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [95:0] m_words [16];
  logic [15:0] m_dc    [16];
  bit          m_loaded[16];
  bit   [7:0]  m_flag  [16];
  bit          acc_load, acc_hit, acc_eoe;
  bit   [15:0] last_roads;

  always #4 clk = ~clk;

  pattern_road_finder i_pattern_road_finder (
    .clk(clk), .rst_n(rst_n), .thresh(thresh),
    .load_valid(load_valid), .load_ready(load_ready), .load_addr(load_addr),
    .load_words(load_words), .load_dc(load_dc),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_words(hit_words),
    .eoe_valid(eoe_valid), .eoe_ready(eoe_ready),
    .road_valid(road_valid), .road_ready(road_ready), .road_addr(road_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [95:0] mk(input logic [11:0] b);
    logic [95:0] r;
    for (int l = 0; l < 8; l++) r[l*12 +: 12] = b + 12'(l * 17);
    return r;
  endfunction

  function automatic bit bmatch(input logic [11:0] s, input logic [1:0] d, input logic [11:0] h);
    int n = (d > 2'd2) ? 2 : int'(d);
    logic [11:0] k = 12'hFFF << n;
    return ((s ^ h) & k) == 12'h000;
  endfunction

  // One cycle of stimulus; the model is updated from what is accepted
  task automatic step(input bit lv, input int la, input logic [95:0] lw, input logic [15:0] ld,
                      input logic [7:0] hv, input logic [95:0] hw, input bit ev);
    @(negedge clk);
    load_valid = lv; load_addr = 4'(la); load_words = lw; load_dc = ld;
    hit_valid = hv; hit_words = hw; eoe_valid = ev;
    #1;
    acc_load = lv && load_ready;
    acc_hit  = hit_ready;
    acc_eoe  = ev && eoe_ready;
    if (acc_hit) begin
      for (int l = 0; l < 8; l++) begin
        if (hv[l]) begin
          for (int p = 0; p < 16; p++) begin
            if (bmatch(m_words[p][l*12 +: 12], m_dc[p][l*2 +: 2], hw[l*12 +: 12]))
              m_flag[p][l] = 1'b1;
          end
        end
      end
    end
    if (acc_load) begin
      m_words[la] = lw; m_dc[la] = ld; m_loaded[la] = 1'b1;
    end
    @(posedge clk); #1;
    load_valid = 1'b0; hit_valid = '0; eoe_valid = 1'b0;
  endtask

  task automatic load_pat(input int a, input logic [95:0] w, input logic [15:0] d);
    step(1'b1, a, w, d, 8'h00, '0, 1'b0);
    check(acc_load, "R1", int'(acc_load), 1);
  endtask

  // End the event (optionally with last hits) and collect/check the roads
  task automatic finish_event(input int th, input int stall_idx,
                              input logic [7:0] hv, input logic [95:0] hw);
    int exp_list[16];
    int n_exp = 0;
    int k = 0;
    thresh = 4'(th);
    step(1'b0, 0, '0, '0, hv, hw, 1'b1);
    check(acc_eoe, "R6", int'(acc_eoe), 1);
    for (int p = 0; p < 16; p++) begin
      if (m_loaded[p] && ($countones(m_flag[p]) >= th)) begin
        exp_list[n_exp] = p; n_exp++;
      end
    end
    @(negedge clk);
    check(!road_valid && !hit_ready, "R11", int'(road_valid), 0);
    last_roads = '0;
    for (int guard = 0; guard < 40; guard++) begin
      @(negedge clk);
      if (!road_valid) break;
      check(k < n_exp && int'(road_addr) == exp_list[k], "R8", int'(road_addr),
            (k < n_exp) ? exp_list[k] : -1);
      last_roads[road_addr] = 1'b1;
      if (k == stall_idx) begin
        logic [3:0] held = road_addr;
        @(negedge clk);
        check(road_valid && road_addr == held, "R8", int'(road_addr), int'(held));
      end
      road_ready = 1'b1;
      @(posedge clk); #1;
      road_ready = 1'b0;
      k++;
    end
    check(k == n_exp, "R4", k, n_exp);
    check(load_ready && hit_ready, "R9", int'(load_ready), 1);
    for (int p = 0; p < 16; p++) m_flag[p] = '0;
  endtask

  task automatic t_reset();
    check(load_ready, "R1", int'(load_ready), 1);
    check(hit_ready && eoe_ready, "R6", int'(hit_ready), 1);
    check(!road_valid, "R9", int'(road_valid), 0);
  endtask

  task automatic t_exact();
    logic [95:0] near = mk(12'h200);
    load_pat(3, mk(12'h100), 16'h0000);
    load_pat(5, mk(12'h200), 16'h0000);
    near[84 +: 12] = near[84 +: 12] + 12'd1;
    step(1'b0, 0, '0, '0, 8'hFF, mk(12'h100), 1'b0);
    step(1'b0, 0, '0, '0, 8'hFF, near, 1'b0);
    finish_event(8, -1, 8'h00, '0);
    check(last_roads == 16'h0008, "R4", int'(last_roads), 16'h0008);
    step(1'b0, 0, '0, '0, 8'hFF, mk(12'h100), 1'b0);
    step(1'b0, 0, '0, '0, 8'hFF, near, 1'b0);
    finish_event(7, -1, 8'h00, '0);
    check(last_roads == 16'h0028, "R4", int'(last_roads), 16'h0028);
  endtask

  task automatic t_dc();
    logic [95:0] base = mk(12'h300);
    logic [95:0] h;
    load_pat(8, base, 16'b0000_0000_0000_01_11_10);
    h = base;
    h[0 +: 12]  = h[0 +: 12]  ^ 12'h003;
    h[12 +: 12] = h[12 +: 12] ^ 12'h003;
    h[24 +: 12] = h[24 +: 12] ^ 12'h001;
    step(1'b0, 0, '0, '0, 8'hFF, h, 1'b0);
    finish_event(8, -1, 8'h00, '0);
    check(last_roads[8], "R2", int'(last_roads[8]), 1);
    h = base;
    h[12 +: 12] = h[12 +: 12] ^ 12'h004;
    step(1'b0, 0, '0, '0, 8'hFF, h, 1'b0);
    finish_event(8, -1, 8'h00, '0);
    check(!last_roads[8], "R2", int'(last_roads[8]), 0);
    h = base;
    h[24 +: 12] = h[24 +: 12] ^ 12'h002;
    step(1'b0, 0, '0, '0, 8'hFF, h, 1'b0);
    finish_event(8, -1, 8'h00, '0);
    check(!last_roads[8], "R2", int'(last_roads[8]), 0);
  endtask

  task automatic t_sticky();
    logic [95:0] base = mk(12'h300);
    step(1'b0, 0, '0, '0, 8'hC0, base, 1'b0);
    step(1'b0, 0, '0, '0, 8'hC0, mk(12'h7A0), 1'b0);
    step(1'b0, 0, '0, '0, 8'h05, base, 1'b0);
    step(1'b0, 0, '0, '0, 8'hFF, mk(12'h9B0), 1'b0);
    step(1'b0, 0, '0, '0, 8'h3A, base, 1'b0);
    finish_event(8, -1, 8'h00, '0);
    check(last_roads == 16'h0100, "R3", int'(last_roads), 16'h0100);
  endtask

  task automatic t_eoe_same();
    step(1'b0, 0, '0, '0, 8'h0F, mk(12'h100), 1'b0);
    finish_event(8, -1, 8'hF0, mk(12'h100));
    check(last_roads == 16'h0008, "R7", int'(last_roads), 16'h0008);
  endtask

  task automatic t_unloaded();
    finish_event(0, -1, 8'h00, '0);
    check(last_roads == 16'h0128, "R5", int'(last_roads), 16'h0128);
  endtask

  task automatic t_load_race();
    step(1'b1, 9, mk(12'h400), 16'h0000, 8'hFF, mk(12'h400), 1'b0);
    check(acc_load && acc_hit, "R10", int'(acc_load), 1);
    @(negedge clk);
    check(!load_ready, "R1", int'(load_ready), 0);
    step(1'b1, 9, mk(12'h500), 16'h0000, 8'h00, '0, 1'b0);
    check(!acc_load, "R1", int'(acc_load), 0);
    finish_event(8, -1, 8'h00, '0);
    check(!last_roads[9], "R10", int'(last_roads[9]), 0);
    step(1'b0, 0, '0, '0, 8'hFF, mk(12'h400), 1'b0);
    finish_event(8, -1, 8'h00, '0);
    check(last_roads == 16'h0200, "R1", int'(last_roads), 16'h0200);
  endtask

  task automatic t_stall();
    load_pat(0, mk(12'h600), 16'h0000);
    load_pat(15, mk(12'h700), 16'h5555);
    finish_event(0, 1, 8'h00, '0);
    check(last_roads == 16'h8329, "R8", int'(last_roads), 16'h8329);
    finish_event(3, -1, 8'h00, '0);
    check(last_roads == 16'h0000, "R9", int'(last_roads), 0);
  endtask

  initial begin
    for (int p = 0; p < 16; p++) begin
      m_words[p] = '0; m_dc[p] = '0; m_loaded[p] = 1'b0; m_flag[p] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_dc();
    t_sticky();
    t_eoe_same();
    t_unloaded();
    t_load_race();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule